// File: doc/BRIEF.md
# Frame Buffer Clear Sequencer

This block owns the single write port of a pixel memory that holds one frame, laid out as a linear array of `H_PIXELS * V_PIXELS` words (320 by 240 by default). It runs two phases, one after the other, without end. In the clear phase it walks every memory address from zero upward and writes the background value. In the draw phase it passes pixel writes from one client through to the memory. The draw phase is much longer than the clear phase. With the default parameters the ratio is 999 to 1, and one clear plus one draw lasts about one 60 Hz frame at the intended fast clock.

Each memory write takes a two-cycle slot, and the address, data and write enable stay fixed for the whole slot. The client raises `req_valid` with an address and a pixel. The request is taken on a rising edge when `req_accept` is high. `busy` tells the client to hold its request. With the default `LAUNCH_ON_FALL` setting, the write port is launched from falling-edge registers. Writes therefore land half a cycle out of step with reads, which are taken on rising edges. `draw_phase` gives the active phase to the display side. `sweep_done` pulses once as each sweep completes.

Top module: `frame_clear_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the block is in the clear phase: `draw_phase`=0, `busy`=1, `sweep_done`=0. From the first falling edge after release, the write port shows `mem_we`=1, `mem_addr`=0 and `mem_data`=`CLEAR_VAL`.
- R2: During a clear sweep, `mem_we` is 1 and `mem_data` is `CLEAR_VAL`. `mem_addr` starts at 0 and goes up by one after exactly two cycles on each address, reaching `H_PIXELS*V_PIXELS-1`. The whole sweep lasts `2*H_PIXELS*V_PIXELS` cycles.
- R3: `draw_phase` is 0 during a clear sweep and 1 during a draw phase. Each draw phase lasts exactly `DRAW_CYCLES` cycles and is then followed by a new sweep that starts at address 0.
- R4: `sweep_done` is high for exactly one cycle, the first cycle of each draw phase, and is low at all other times.
- R5: `busy` is 1 during the whole clear phase. `req_accept` equals `req_valid AND NOT busy`, so no request is accepted while clearing.
- R6: A request accepted at a rising edge drives `mem_we`=1 with its `req_addr` and `req_data` on the write port for the next two cycles.
- R7: In a draw-phase cycle that is not inside an accepted two-cycle write slot, `mem_we` is 0.
- R8: In the draw phase, `busy` is 1 in the first cycle of a client write slot and 0 in its second cycle, unless R9 applies. A client that holds `req_valid` high therefore gets one write accepted every two cycles.
- R9: `busy` is 1 and `req_accept` is 0 in the last two cycles of every draw phase, so every client write ends before the next sweep begins.
- R10: With `LAUNCH_ON_FALL`=1, the write port changes only on falling edges. Just after a rising edge it still shows the values of the cycle that edge ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; control state moves on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Client has a pixel write pending |
| req_addr | input | ADDR_W | Linear pixel address of the client write |
| req_data | input | PIX_W | Pixel value of the client write |
| req_accept | output | 1 | Request is taken at the next rising edge |
| busy | output | 1 | Client must hold its request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_data | output | PIX_W | Memory write data |
| draw_phase | output | 1 | 1 in the draw phase, 0 during a clear sweep |
| sweep_done | output | 1 | One-cycle pulse in the first draw cycle after a sweep |

## Verification
The embedded assertions check the local invariants on every cycle. The sweep address never leaves the memory range and only moves after the second beat. A sweep always starts from address 0. `sweep_done` lasts one cycle and comes only at the start of a draw phase. A client write keeps its values for both beats. No request is accepted while clearing or in the two-cycle tail of a draw phase. Only the bench's scenarios can show the end-to-end behaviour: the exact length of each sweep and each draw phase, back-to-back client writes under a saturating request stream, writes that race the draw-phase tail, and the half-cycle launch of the write port against the rising edge.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

   typedef enum logic {
      PH_CLEAR = 1'b0,
      PH_DRAW  = 1'b1
   } fbc_phase_e;

endpackage

// File: rtl/fbc_sweep_counter.sv
module fbc_sweep_counter #(
   parameter int DEPTH  = 76800,
   parameter int ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   output logic [ADDR_W-1:0] addr,
   output logic              beat,
   output logic              last_beat
);

   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

   assign last_beat = run && beat && (addr == LAST_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
         beat <= 1'b0;
      end else if (!run) begin
         addr <= '0;
         beat <= 1'b0;
      end else begin
         beat <= ~beat;
         if (beat) begin
            addr <= (addr == LAST_ADDR) ? '0 : addr + 1'b1;
         end
      end
   end

   assert_addr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      addr <= LAST_ADDR)
      else $error("sweep address out of range");

   assert_addr_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !beat) |=> (addr == $past(addr)))
      else $error("sweep address moved after a single beat");

endmodule

// File: rtl/fbc_phase_ctrl.sv
module fbc_phase_ctrl import fbc_pkg::*; #(
   parameter int DRAW_CYCLES = 153446400
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sweep_last,
   output fbc_phase_e phase,
   output logic       draw_tail,
   output logic       sweep_done
);

   localparam int CNT_W = $clog2(DRAW_CYCLES);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DRAW_CYCLES - 1);
   localparam logic [CNT_W-1:0] CNT_TAIL = CNT_W'(DRAW_CYCLES - 2);

   logic [CNT_W-1:0] draw_cnt;

   assign draw_tail = (phase == PH_DRAW) && (draw_cnt >= CNT_TAIL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_CLEAR;
         draw_cnt   <= '0;
         sweep_done <= 1'b0;
      end else begin
         sweep_done <= 1'b0;
         case (phase)
            PH_CLEAR: begin
               draw_cnt <= '0;
               if (sweep_last) begin
                  phase      <= PH_DRAW;
                  sweep_done <= 1'b1;
               end
            end
            default: begin
               if (draw_cnt == CNT_LAST) begin
                  phase    <= PH_CLEAR;
                  draw_cnt <= '0;
               end else begin
                  draw_cnt <= draw_cnt + 1'b1;
               end
            end
         endcase
      end
   end

   assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_done |=> !sweep_done)
      else $error("sweep_done longer than one cycle");

   assert_done_opens_draw_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_done |-> (phase == PH_DRAW && draw_cnt == '0))
      else $error("sweep_done outside the first draw cycle");

endmodule

// File: rtl/fbc_client_slot.sv
module fbc_client_slot #(
   parameter int ADDR_W = 17,
   parameter int PIX_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [PIX_W-1:0]  req_data,
   output logic              we,
   output logic              first,
   output logic [ADDR_W-1:0] addr,
   output logic [PIX_W-1:0]  data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we    <= 1'b0;
         first <= 1'b0;
         addr  <= '0;
         data  <= '0;
      end else if (accept) begin
         we    <= 1'b1;
         first <= 1'b1;
         addr  <= req_addr;
         data  <= req_data;
      end else if (we && first) begin
         first <= 1'b0;
      end else begin
         we    <= 1'b0;
         first <= 1'b0;
      end
   end

   assert_slot_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (we && first && addr == $past(req_addr) && data == $past(req_data)))
      else $error("accepted write not loaded");

   assert_slot_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (we && first) |=> (we && !first && $stable(addr) && $stable(data)))
      else $error("client write not held for its second beat");

endmodule

// File: rtl/fbc_launch_stage.sv
module fbc_launch_stage #(
   parameter int ADDR_W         = 17,
   parameter int PIX_W          = 16,
   parameter bit LAUNCH_ON_FALL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_in,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [PIX_W-1:0]  data_in,
   output logic              we_out,
   output logic [ADDR_W-1:0] addr_out,
   output logic [PIX_W-1:0]  data_out
);

   generate
      if (LAUNCH_ON_FALL) begin : g_fall
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) begin
               we_out   <= 1'b0;
               addr_out <= '0;
               data_out <= '0;
            end else begin
               we_out   <= we_in;
               addr_out <= addr_in;
               data_out <= data_in;
            end
         end
      end else begin : g_direct
         assign we_out   = we_in;
         assign addr_out = addr_in;
         assign data_out = data_in;
      end
   endgenerate

endmodule

// File: rtl/frame_clear_sequencer.sv
module frame_clear_sequencer import fbc_pkg::*; #(
   parameter int               H_PIXELS       = 320,
   parameter int               V_PIXELS       = 240,
   parameter int               PIX_W          = 16,
   parameter int               DRAW_CYCLES    = 153446400,
   parameter logic [PIX_W-1:0] CLEAR_VAL      = '0,
   parameter bit               LAUNCH_ON_FALL = 1'b1,
   localparam int              DEPTH          = H_PIXELS * V_PIXELS,
   localparam int              ADDR_W         = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [PIX_W-1:0]  req_data,
   output logic              req_accept,
   output logic              busy,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [PIX_W-1:0]  mem_data,
   output logic              draw_phase,
   output logic              sweep_done
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("frame must hold at least two pixels");
      end
      if (DRAW_CYCLES < 4) begin : g_bad_draw
         $error("DRAW_CYCLES must be at least 4");
      end
      if (PIX_W < 1) begin : g_bad_width
         $error("PIX_W must be positive");
      end
   endgenerate

   fbc_phase_e        phase;
   logic              draw_tail;
   logic [ADDR_W-1:0] sw_addr;
   logic              sw_beat;
   logic              sw_last;
   logic              cl_we;
   logic              cl_first;
   logic [ADDR_W-1:0] cl_addr;
   logic [PIX_W-1:0]  cl_data;
   logic              int_we;
   logic [ADDR_W-1:0] int_addr;
   logic [PIX_W-1:0]  int_data;

   assign draw_phase = (phase == PH_DRAW);
   assign busy       = !draw_phase || (cl_we && cl_first) || draw_tail;
   assign req_accept = req_valid && !busy;

   fbc_sweep_counter #(
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W)
   ) u_sweep (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (!draw_phase),
      .addr      (sw_addr),
      .beat      (sw_beat),
      .last_beat (sw_last)
   );

   fbc_phase_ctrl #(
      .DRAW_CYCLES (DRAW_CYCLES)
   ) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .sweep_last (sw_last),
      .phase      (phase),
      .draw_tail  (draw_tail),
      .sweep_done (sweep_done)
   );

   fbc_client_slot #(
      .ADDR_W (ADDR_W),
      .PIX_W  (PIX_W)
   ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (req_accept),
      .req_addr (req_addr),
      .req_data (req_data),
      .we       (cl_we),
      .first    (cl_first),
      .addr     (cl_addr),
      .data     (cl_data)
   );

   always_comb begin
      if (draw_phase) begin
         int_we   = cl_we;
         int_addr = cl_addr;
         int_data = cl_data;
      end else begin
         int_we   = 1'b1;
         int_addr = sw_addr;
         int_data = CLEAR_VAL;
      end
   end

   fbc_launch_stage #(
      .ADDR_W         (ADDR_W),
      .PIX_W          (PIX_W),
      .LAUNCH_ON_FALL (LAUNCH_ON_FALL)
   ) u_launch (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_in    (int_we),
      .addr_in  (int_addr),
      .data_in  (int_data),
      .we_out   (mem_we),
      .addr_out (mem_addr),
      .data_out (mem_data)
   );

   assert_clear_no_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !draw_phase |-> !req_accept)
      else $error("request accepted during clear sweep");

   assert_tail_no_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      draw_tail |-> !req_accept)
      else $error("request accepted in draw tail");

   assert_sweep_starts_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(draw_phase) |-> (sw_addr == '0 && !sw_beat))
      else $error("sweep did not restart at address zero");

   assert_clear_stream_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!draw_phase && !sw_last) |=> (!draw_phase && int_we))
      else $error("clear sweep ended early");

endmodule

// File: tb/tb_frame_clear_sequencer.sv
`timescale 1ns/1ps
module tb_frame_clear_sequencer;

   localparam int          H   = 8;
   localparam int          V   = 4;
   localparam int          N   = H * V;
   localparam int          D   = 60;
   localparam int          PW  = 8;
   localparam int          AW  = $clog2(N);
   localparam logic [PW-1:0] CLR = 8'hA5;
   localparam int          RUN_CYCLES = 560;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [PW-1:0] req_data = '0;
   logic          req_accept, busy, mem_we, draw_phase, sweep_done;
   logic [AW-1:0] mem_addr;
   logic [PW-1:0] mem_data;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   frame_clear_sequencer #(
      .H_PIXELS       (H),
      .V_PIXELS       (V),
      .PIX_W          (PW),
      .DRAW_CYCLES    (D),
      .CLEAR_VAL      (CLR),
      .LAUNCH_ON_FALL (1'b1)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .req_data   (req_data),
      .req_accept (req_accept),
      .busy       (busy),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_data   (mem_data),
      .draw_phase (draw_phase),
      .sweep_done (sweep_done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit exp_busy(bit draw, bit we, bit first, int cnt);
      return !draw || (we && first) || (cnt >= D - 2);
   endfunction

   // reference model state (cycle-level, from requirements)
   bit m_draw, m_beat, m_done, m_we, m_first;
   int m_addr, m_cnt, m_wa, m_wd;
   bit p_we;
   int p_addr, p_data;
   int run_len;
   bit run_draw;

   initial begin : watchdog
      #(20 * 200000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      bit e_we, e_busy, e_acc;
      int e_addr, e_data;
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      // R1: state while reset held
      #2;
      check(draw_phase == 1'b0, "R1", "draw_phase in reset", int'(draw_phase), 0);
      check(busy == 1'b1, "R1", "busy in reset", int'(busy), 1);
      check(sweep_done == 1'b0, "R1", "sweep_done in reset", int'(sweep_done), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      m_draw = 0; m_beat = 0; m_done = 0; m_we = 0; m_first = 0;
      m_addr = 0; m_cnt = 0; m_wa = 0; m_wd = 0;
      run_len = 0; run_draw = 0;
      for (int t = 0; t < RUN_CYCLES; t++) begin
         int pct;
         // drive client request for this cycle
         pct = (t < 200) ? 100 : ((t < 400) ? 50 : 20);
         req_valid = (($urandom % 100) < pct);
         req_addr  = AW'($urandom % N);
         req_data  = PW'($urandom);
         // R10: port still shows previous cycle values just after rising edge
         if (t > 0) begin
            check(mem_we == p_we, "R10", "mem_we before fall launch", int'(mem_we), int'(p_we));
            if (p_we)
               check(int'(mem_addr) == p_addr, "R10", "mem_addr before fall launch",
                     int'(mem_addr), p_addr);
         end
         @(negedge clk); #2;
         e_we   = m_draw ? m_we : 1'b1;
         e_addr = m_draw ? m_wa : m_addr;
         e_data = m_draw ? m_wd : int'(CLR);
         e_busy = exp_busy(m_draw, m_we, m_first, m_cnt);
         e_acc  = req_valid && !e_busy;
         if (t == 0) begin
            check(mem_we && mem_addr == '0 && mem_data == CLR, "R1", "first write after reset",
                  int'(mem_addr), 0);
         end
         check(draw_phase == m_draw, "R3", "draw_phase", int'(draw_phase), int'(m_draw));
         check(sweep_done == m_done, "R4", "sweep_done", int'(sweep_done), int'(m_done));
         check(req_accept == e_acc, "R5", "req_accept", int'(req_accept), int'(e_acc));
         if (!m_draw) begin
            check(busy == 1'b1, "R5", "busy in clear", int'(busy), 1);
            check(mem_we == 1'b1, "R2", "mem_we in sweep", int'(mem_we), 1);
            check(int'(mem_addr) == e_addr, "R2", "sweep address", int'(mem_addr), e_addr);
            check(int'(mem_data) == e_data, "R2", "sweep data", int'(mem_data), e_data);
         end else begin
            if (m_cnt >= D - 2) begin
               check(busy == 1'b1, "R9", "busy in tail", int'(busy), 1);
               check(req_accept == 1'b0, "R9", "accept in tail", int'(req_accept), 0);
            end else begin
               check(busy == e_busy, "R8", "busy in draw", int'(busy), int'(e_busy));
            end
            if (m_we) begin
               check(mem_we == 1'b1, "R6", "client mem_we", int'(mem_we), 1);
               check(int'(mem_addr) == e_addr, "R6", "client address", int'(mem_addr), e_addr);
               check(int'(mem_data) == e_data, "R6", "client data", int'(mem_data), e_data);
            end else begin
               check(mem_we == 1'b0, "R7", "idle mem_we", int'(mem_we), 0);
            end
         end
         // phase run lengths measured at the ports
         if (t > 0 && draw_phase != run_draw) begin
            if (run_draw)
               check(run_len == D, "R3", "draw phase length", run_len, D);
            else
               check(run_len == 2 * N, "R2", "sweep length", run_len, 2 * N);
            run_len = 0;
         end
         run_draw = draw_phase;
         run_len++;
         p_we = mem_we; p_addr = int'(mem_addr); p_data = int'(mem_data);
         // advance model to the next cycle
         if (!m_draw) begin
            if (m_beat && m_addr == N - 1) begin
               m_draw = 1; m_cnt = 0; m_done = 1; m_addr = 0; m_beat = 0;
            end else begin
               m_done = 0;
               if (m_beat) m_addr++;
               m_beat = !m_beat;
            end
         end else begin
            m_done = 0;
            if (m_cnt == D - 1) begin
               m_draw = 0; m_cnt = 0;
            end else begin
               m_cnt++;
            end
         end
         if (e_acc) begin
            m_we = 1; m_first = 1; m_wa = int'(req_addr); m_wd = int'(req_data);
         end else if (m_we && m_first) begin
            m_first = 0;
         end else begin
            m_we = 0; m_first = 0;
         end
         @(posedge clk); #1;
      end
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule